// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small set of token latches shared between a left and a right port. Software on either side uses them to claim and hand back shared resources. The latches are separate from any memory array. A port picks a latch with a 3-bit index and requests its token by writing 0 on its single write-data bit. It releases the token, or withdraws a request, by writing 1. Reading gives the ownership status as seen from the reading side: 0 means "this side holds the token" and 1 means "it does not".

Each latch remembers a request from each side. When the holder lets go, a waiting request from the other side is granted on the same clock edge, so the waiting side does not have to poll for the token and then write again. If both sides request a free latch in the same clock, the left port wins and the right request stays pending. A read is captured into a per-port output register when the read access begins. While that access continues, a write from the other port cannot change what the reader sees.

An access to a latch requires the port's semaphore select to be low and its memory chip enable to be high. An access with both low is illegal and is ignored. All state is synchronous to `clk_i`. `rst_ni` is an asynchronous, active-low reset.

Top module: `sem_unit`

## Requirements
- R1: After reset every latch is free with no pending request, and both read-data buses show 8'hFF.
- R2: A request (write with data bit 0) to a free latch makes that side the owner: it reads 8'h00 and the other side reads 8'hFF for that latch.
- R3: The 3-bit index selects exactly one of the eight latches; accesses to one latch leave every other latch unchanged.
- R4: A request from the non-owning side is held pending; when the owner writes 1, the pending side becomes owner on that same clock edge.
- R5: A side that writes 1 while its request is still pending withdraws it without changing ownership, and it is not granted on a later release.
- R6: When both sides request the same free latch in the same clock, the left side becomes owner and the right request stays pending.
- R7: No latch is ever owned by both sides at once.
- R8: A read access (select low, chip enable high, read/write high, output enable low) loads the read register on its first clock, or on any clock where the index changes; while it continues on the same index the register holds, even if the other side changes ownership.
- R9: A write with both select and chip enable low, or with select high, changes no latch state.
- R10: A read drives the status bit on all eight data lines, so the read data is always 8'h00 or 8'hFF.
- R11: Writing 1 to a latch that the side neither owns nor requests has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_ni | input | 1 | Left semaphore select, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low (must be high for a latch access) |
| l_wr_ni | input | 1 | Left read/write: 0 write, 1 read |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_idx_i | input | 3 | Left latch index |
| l_wbit_i | input | 1 | Left write data bit (0 request, 1 release) |
| l_rdata_o | output | 8 | Left latched read data |
| r_sel_ni | input | 1 | Right semaphore select, active low |
| r_ce_ni | input | 1 | Right memory chip enable, active low (must be high for a latch access) |
| r_wr_ni | input | 1 | Right read/write: 0 write, 1 read |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_idx_i | input | 3 | Right latch index |
| r_wbit_i | input | 1 | Right write data bit (0 request, 1 release) |
| r_rdata_o | output | 8 | Right latched read data |

## Verification
The hardest situation to reach from the ports is a handover that happens while the waiting side is in the middle of a read of the same latch. The status changes underneath the reader, and the latched value must not follow it. Directed sequences build this case on purpose: one side requests and then starts a long read, and the other side releases during that read. The same kind of sequence also drives same-cycle requests from both sides and a request that is withdrawn before it is granted. A constrained random phase confines both ports to three latches and mixes requests, releases, reads and illegal accesses, so that contention and mid-read changes come up often. Every cycle of that phase is compared against a bench model.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic wbit;
  } port_op_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3
) (
  input  logic               sel_ni,
  input  logic               ce_ni,
  input  logic               wr_ni,
  input  logic               oe_ni,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wbit_i,
  output port_op_t           op_o,
  output logic [NUM_SEM-1:0] wsel_o
);
  logic acc;

  // latch access only with select low and memory enable high
  assign acc       = ~sel_ni & ce_ni;
  assign op_o.wr   = acc & ~wr_ni;
  assign op_o.rd   = acc & wr_ni & ~oe_ni;
  assign op_o.wbit = wbit_i;

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_sel
    assign wsel_o[k] = op_o.wr && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_wr_i,
  input  logic l_wbit_i,
  input  logic r_wr_i,
  input  logic r_wbit_i,
  output logic own_l_o,
  output logic own_r_o,
  output logic req_l_o,
  output logic req_r_o
);
  logic req_l_q, req_r_q, req_l_d, req_r_d;
  own_e own_q, own_d;

  always_comb begin
    req_l_d = l_wr_i ? ~l_wbit_i : req_l_q;
    req_r_d = r_wr_i ? ~r_wbit_i : req_r_q;
    own_d   = OWN_NONE;
    if (own_q == OWN_LEFT && req_l_d)       own_d = OWN_LEFT;
    else if (own_q == OWN_RIGHT && req_r_d) own_d = OWN_RIGHT;
    else if (req_l_d)                       own_d = OWN_LEFT;  // left wins ties
    else if (req_r_d)                       own_d = OWN_RIGHT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      own_q   <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_q   <= own_d;
    end
  end

  assign own_l_o = (own_q == OWN_LEFT);
  assign own_r_o = (own_q == OWN_RIGHT);
  assign req_l_o = req_l_q;
  assign req_r_o = req_r_q;
endmodule

// File: rtl/sem_rd_latch.sv
module sem_rd_latch #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_SEM-1:0] own_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic             rd_q;
  logic [IDX_W-1:0] idx_q;
  logic             load;

  // capture only at the start of an access or on an index change
  assign load = rd_i && (!rd_q || idx_i != idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      idx_q   <= '0;
      rdata_o <= '1;
    end else begin
      rd_q  <= rd_i;
      idx_q <= idx_i;
      if (load) rdata_o <= {DATA_W{~own_i[idx_i]}};
    end
  end
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_ni,
  input  logic              l_ce_ni,
  input  logic              l_wr_ni,
  input  logic              l_oe_ni,
  input  logic [IDX_W-1:0]  l_idx_i,
  input  logic              l_wbit_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sel_ni,
  input  logic              r_ce_ni,
  input  logic              r_wr_ni,
  input  logic              r_oe_ni,
  input  logic [IDX_W-1:0]  r_idx_i,
  input  logic              r_wbit_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  port_op_t           l_op, r_op;
  logic [NUM_SEM-1:0] l_wsel, r_wsel;
  logic [NUM_SEM-1:0] own_l, own_r, req_l, req_r;

  sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
    .sel_ni(l_sel_ni), .ce_ni(l_ce_ni), .wr_ni(l_wr_ni), .oe_ni(l_oe_ni),
    .idx_i(l_idx_i), .wbit_i(l_wbit_i), .op_o(l_op), .wsel_o(l_wsel)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
    .sel_ni(r_sel_ni), .ce_ni(r_ce_ni), .wr_ni(r_wr_ni), .oe_ni(r_oe_ni),
    .idx_i(r_idx_i), .wbit_i(r_wbit_i), .op_o(r_op), .wsel_o(r_wsel)
  );

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_cell
    sem_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .l_wr_i  (l_wsel[k]),
      .l_wbit_i(l_op.wbit),
      .r_wr_i  (r_wsel[k]),
      .r_wbit_i(r_op.wbit),
      .own_l_o (own_l[k]),
      .own_r_o (own_r[k]),
      .req_l_o (req_l[k]),
      .req_r_o (req_r[k])
    );
  end

  sem_rd_latch #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(l_op.rd), .idx_i(l_idx_i),
    .own_i(own_l), .rdata_o(l_rdata_o)
  );

  sem_rd_latch #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(r_op.rd), .idx_i(r_idx_i),
    .own_i(own_r), .rdata_o(r_rdata_o)
  );
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_sel_ni,
  input logic               l_ce_ni,
  input logic               l_wr_ni,
  input logic               l_oe_ni,
  input logic [IDX_W-1:0]   l_idx_i,
  input logic               r_sel_ni,
  input logic               r_ce_ni,
  input logic               r_wr_ni,
  input logic               r_oe_ni,
  input logic [IDX_W-1:0]   r_idx_i,
  input logic [DATA_W-1:0]  l_rdata_o,
  input logic [DATA_W-1:0]  r_rdata_o,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r,
  input logic [NUM_SEM-1:0] req_l,
  input logic [NUM_SEM-1:0] req_r
);
  logic past_ok;
  logic l_rd, r_rd, l_ill, r_wr_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign l_rd     = ~l_sel_ni & l_ce_ni & l_wr_ni & ~l_oe_ni;
  assign r_rd     = ~r_sel_ni & r_ce_ni & r_wr_ni & ~r_oe_ni;
  assign l_ill    = ~l_sel_ni & ~l_ce_ni;
  assign r_wr_any = ~r_sel_ni & r_ce_ni & ~r_wr_ni;

  a_r7_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  a_r10_all_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rdata_o == '0 || l_rdata_o == '1) && (r_rdata_o == '0 || r_rdata_o == '1));

  a_r8_left_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && l_rd && $past(l_rd) && $stable(l_idx_i)) |=> $stable(l_rdata_o));

  a_r8_right_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && r_rd && $past(r_rd) && $stable(r_idx_i)) |=> $stable(r_rdata_o));

  a_r9_illegal_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ill && !r_wr_any) |=> ($stable(own_l) && $stable(own_r) && $stable(req_l)));

  a_r4_handover_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(own_l) & $past(req_r) & req_r & ~own_l & ~own_r) == '0);

  a_r4_handover_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(own_r) & $past(req_l) & req_l & ~own_r & ~own_l) == '0);
endmodule

bind sem_unit sem_unit_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_sel_ni(l_sel_ni), .l_ce_ni(l_ce_ni), .l_wr_ni(l_wr_ni), .l_oe_ni(l_oe_ni),
  .l_idx_i(l_idx_i),
  .r_sel_ni(r_sel_ni), .r_ce_ni(r_ce_ni), .r_wr_ni(r_wr_ni), .r_oe_ni(r_oe_ni),
  .r_idx_i(r_idx_i),
  .l_rdata_o(l_rdata_o), .r_rdata_o(r_rdata_o),
  .own_l(own_l), .own_r(own_r), .req_l(req_l), .req_r(req_r)
);

// File: tb/tb_sem_unit.sv
`timescale 1ns/1ps
module tb_sem_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       l_sel_ni, l_ce_ni, l_wr_ni, l_oe_ni, l_wbit_i;
  logic       r_sel_ni, r_ce_ni, r_wr_ni, r_oe_ni, r_wbit_i;
  logic [2:0] l_idx_i, r_idx_i;
  logic [7:0] l_rdata_o, r_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  // bench model
  bit       m_ol[8], m_or[8], m_rl[8], m_rr[8];
  bit [7:0] m_ldat = 8'hFF, m_rdat = 8'hFF;
  bit       m_lrdq = 0, m_rrdq = 0;
  bit [2:0] m_lidxq = 0, m_ridxq = 0;

  always #5 clk_i = ~clk_i;

  sem_unit dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    bit la, ra, lw, rw, lr, rr, nl, nr;
    la = !l_sel_ni && l_ce_ni;  ra = !r_sel_ni && r_ce_ni;
    lw = la && !l_wr_ni;        rw = ra && !r_wr_ni;
    lr = la && l_wr_ni && !l_oe_ni;
    rr = ra && r_wr_ni && !r_oe_ni;
    if (lr && (!m_lrdq || l_idx_i != m_lidxq)) m_ldat = m_ol[l_idx_i] ? 8'h00 : 8'hFF;
    if (rr && (!m_rrdq || r_idx_i != m_ridxq)) m_rdat = m_or[r_idx_i] ? 8'h00 : 8'hFF;
    m_lrdq = lr; m_rrdq = rr; m_lidxq = l_idx_i; m_ridxq = r_idx_i;
    for (int k = 0; k < 8; k++) begin
      nl = (lw && l_idx_i == 3'(k)) ? !l_wbit_i : m_rl[k];
      nr = (rw && r_idx_i == 3'(k)) ? !r_wbit_i : m_rr[k];
      if (m_ol[k] && nl) begin end
      else if (m_or[k] && nr) begin end
      else begin m_ol[k] = nl; m_or[k] = !nl && nr; end
      if (!m_ol[k] && !m_or[k] && nl) m_ol[k] = 1;
      m_rl[k] = nl; m_rr[k] = nr;
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    model_tick();
    @(negedge clk_i);
    chk({cur_tag, " model L"}, l_rdata_o, m_ldat);
    chk({cur_tag, " model R"}, r_rdata_o, m_rdat);
  endtask

  task automatic idle();
    {l_sel_ni, l_ce_ni, l_wr_ni, l_oe_ni} = 4'b1111;
    {r_sel_ni, r_ce_ni, r_wr_ni, r_oe_ni} = 4'b1111;
  endtask

  task automatic set_wr(input bit right, input bit [2:0] idx, input bit b);
    if (!right) begin l_sel_ni = 0; l_ce_ni = 1; l_wr_ni = 0; l_oe_ni = 1; l_idx_i = idx; l_wbit_i = b; end
    else        begin r_sel_ni = 0; r_ce_ni = 1; r_wr_ni = 0; r_oe_ni = 1; r_idx_i = idx; r_wbit_i = b; end
  endtask

  task automatic set_rd(input bit right, input bit [2:0] idx);
    if (!right) begin l_sel_ni = 0; l_ce_ni = 1; l_wr_ni = 1; l_oe_ni = 0; l_idx_i = idx; end
    else        begin r_sel_ni = 0; r_ce_ni = 1; r_wr_ni = 1; r_oe_ni = 0; r_idx_i = idx; end
  endtask

  task automatic wr(input bit right, input bit [2:0] idx, input bit b);
    set_wr(right, idx, b); step(); idle();
  endtask

  task automatic rd_chk(input bit right, input bit [2:0] idx, input logic [7:0] exp, input string tag);
    set_rd(right, idx); step();
    chk(tag, right ? r_rdata_o : l_rdata_o, exp);
    idle(); step();
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    idle(); l_idx_i = 0; r_idx_i = 0; l_wbit_i = 1; r_wbit_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R1 reset L", l_rdata_o, 8'hFF);
    chk("R1 reset R", r_rdata_o, 8'hFF);
    rst_ni = 1;
    step();
    for (int k = 0; k < 8; k++) begin
      rd_chk(0, 3'(k), 8'hFF, "R1 free L");
      rd_chk(1, 3'(k), 8'hFF, "R1 free R");
    end

    cur_tag = "R2";
    wr(0, 3, 0);
    rd_chk(0, 3, 8'h00, "R2 owner L");
    rd_chk(1, 3, 8'hFF, "R2 other R");
    rd_chk(0, 2, 8'hFF, "R3 neighbour 2");
    rd_chk(0, 4, 8'hFF, "R3 neighbour 4");

    cur_tag = "R4";
    wr(1, 3, 0);
    rd_chk(1, 3, 8'hFF, "R4 pending R");
    wr(0, 3, 1);
    rd_chk(1, 3, 8'h00, "R4 handover R");
    rd_chk(0, 3, 8'hFF, "R4 released L");

    cur_tag = "R5";
    wr(0, 3, 0);
    wr(0, 3, 1);
    rd_chk(1, 3, 8'h00, "R5 owner kept R");
    wr(1, 3, 1);
    rd_chk(0, 3, 8'hFF, "R5 cancelled L");
    rd_chk(1, 3, 8'hFF, "R5 free R");

    cur_tag = "R11";
    wr(0, 5, 1);
    rd_chk(0, 5, 8'hFF, "R11 stray release L");
    wr(1, 5, 0);
    wr(0, 5, 1);
    rd_chk(1, 5, 8'h00, "R11 owner intact R");
    wr(1, 5, 1);

    cur_tag = "R6";
    set_wr(0, 6, 0); set_wr(1, 6, 0); step(); idle();
    rd_chk(0, 6, 8'h00, "R6 tie to L");
    rd_chk(1, 6, 8'hFF, "R6 loser R");
    wr(0, 6, 1);
    rd_chk(1, 6, 8'h00, "R6 pending granted R");
    wr(1, 6, 1);

    cur_tag = "R9";
    set_wr(0, 7, 0); l_ce_ni = 0; step(); idle();
    rd_chk(0, 7, 8'hFF, "R9 both enables low");
    set_wr(1, 7, 0); r_sel_ni = 1; step(); idle();
    rd_chk(1, 7, 8'hFF, "R9 select high");

    cur_tag = "R8";
    wr(0, 1, 0);
    wr(1, 1, 0);
    set_rd(1, 1); step();
    chk("R8 read start R", r_rdata_o, 8'hFF);
    set_wr(0, 1, 1); step(); l_sel_ni = 1; l_wr_ni = 1;
    step(); step();
    chk("R8 held across handover R", r_rdata_o, 8'hFF);
    idle(); step();
    rd_chk(1, 1, 8'h00, "R8 new access R");
    chk("R10 all lines low", r_rdata_o, 8'h00);
    wr(1, 1, 1);

    cur_tag = "R7 random";
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      idle();
      op = $urandom_range(0, 3);
      case (op)
        0: set_wr(0, 3'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
        1: set_rd(0, 3'($urandom_range(0, 2)));
        2: begin set_wr(0, 3'($urandom_range(0, 2)), 0); l_ce_ni = 0; end
        default: ;
      endcase
      op = $urandom_range(0, 3);
      case (op)
        0: set_wr(1, 3'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
        1: set_rd(1, 3'($urandom_range(0, 2)));
        2: begin set_wr(1, 3'($urandom_range(0, 2)), 0); r_ce_ni = 0; end
        default: ;
      endcase
      step();
    end
    idle(); step();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule